// File: doc/BRIEF.md
# DMA Control Register Front End

This block is the host-facing register file of a bus-mastering DMA engine that sits next to a SCSI protocol controller on an expansion card. The host reaches it through a simple single-cycle register port. A control register holds an interrupt-enable bit and a transfer-direction bit, and it shows a pending-interrupt flag and a busy flag. A 32-bit register holds the transfer address. A small bank register supplies address bits 26:24. Two strobe locations start and stop the transfer, and a write of any value to either one acts.

The block sends one-cycle start and stop pulses to the transfer engine. It tracks whether a transfer is running. It forwards the protocol controller's interrupt request to the host, gated by the enable bit. A programmable reach mask marks the address bits the engine cannot drive, and the block raises an out-of-range flag when the loaded address sets any of them. A read-only status word reports the strap that selects the protocol controller's clock range. Software uses that strap to choose between the 8–10 MHz and the 12–15 MHz timing.

Top module: `dmafe_top`

## Requirements
- R1: After reset, these hold:
  - the control word reads 0;
  - the start pulse, stop pulse and host interrupt are low;
  - the bank reads 0;
  - the reach mask (offset 0x14) reads its default 0xFF000000.
- R2: A write of any data to offset 0x0C makes `eng_start_o` high for exactly the cycle after the write, and it sets the busy flag (control bit 3).
- R3: A write of any data to offset 0x10 makes `eng_stop_o` high for exactly the cycle after the write. It clears busy and does not set pending.
- R4: `eng_done_i` seen while busy clears busy and sets pending (control bit 2). `eng_done_i` seen while idle has no effect.
- R5: `host_irq_o` is high only while pending is set and interrupt enable (control bit 0) is set.
- R6: A read of the control word (offset 0x00) clears pending. If a set source is active in the same cycle, pending stays set.
- R7: A control write changes only enable (bit 0) and direction (bit 1, 1 = memory to device). `eng_dir_o` follows bit 1. Bits 2 and 3 ignore written data.
- R8: The address register (offset 0x04) reads back all 32 written bits. `eng_addr_o` equals that address with bits 26:24 replaced by the bank value.
- R9: A bank write (offset 0x08) takes write data bits 8:6 and keeps only the bits whose matching reach-mask bit 26:24 is clear. The bank reads back at bits 8:6.
- R10: `range_err_o` is high exactly when the address register and the reach mask share a set bit.
- R11: A chip interrupt (`chip_irq_i` high) sets pending.
- R12: Offset 0x8000 reads `clk_sel_i` in bit 0 with zeros above it. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write this cycle |
| rd_en | input | 1 | Register read this cycle (carries read side effects) |
| addr | input | ADDR_W | Byte offset of the register access |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr`, valid in the same cycle |
| clk_sel_i | input | 1 | Clock-range strap of the protocol controller |
| eng_done_i | input | 1 | Transfer engine reports completion |
| chip_irq_i | input | 1 | Interrupt request from the protocol controller |
| eng_start_o | output | 1 | One-cycle start pulse to the engine |
| eng_stop_o | output | 1 | One-cycle stop pulse to the engine |
| eng_dir_o | output | 1 | Transfer direction, 1 = memory to device |
| eng_addr_o | output | DATA_W | Transfer address with bank bits merged |
| range_err_o | output | 1 | Loaded address outside the reachable range |
| host_irq_o | output | 1 | Gated interrupt to the host |

## Verification
The hardest case to reach is a control-word read that lands in the same cycle as a new interrupt source. A bench that only reads after events would never show whether the clear or the set wins. The stimulus therefore holds the chip interrupt high across a control read, and then reads again with the line low, to show that pending survived the first read and cleared on the second. The bank masking is reached the same way: the reach mask is reprogrammed to each of the three supported limits before the same bank value is written.

// File: rtl/dmafe_pkg.sv
package dmafe_pkg;

    // Register byte offsets
    localparam int OFF_CTRL   = 'h0000;
    localparam int OFF_ADDR   = 'h0004;
    localparam int OFF_BANK   = 'h0008;
    localparam int OFF_START  = 'h000C;
    localparam int OFF_STOP   = 'h0010;
    localparam int OFF_MASK   = 'h0014;
    localparam int OFF_CLKSEL = 'h8000;

    // Control word bit positions
    localparam int B_IE   = 0;
    localparam int B_DIR  = 1;
    localparam int B_PEND = 2;
    localparam int B_BUSY = 3;

    typedef struct packed {
        logic wr_ctrl;
        logic wr_addr;
        logic wr_bank;
        logic wr_start;
        logic wr_stop;
        logic wr_mask;
        logic rd_ctrl;
    } dec_t;

    typedef struct packed {
        logic busy;
        logic pend;
        logic dir;
        logic ie;
    } ctrl_t;

    function automatic logic [31:0] ctrl_word(ctrl_t c);
        logic [31:0] w;
        w         = '0;
        w[B_IE]   = c.ie;
        w[B_DIR]  = c.dir;
        w[B_PEND] = c.pend;
        w[B_BUSY] = c.busy;
        return w;
    endfunction

endpackage

// File: rtl/dmafe_decode.sv
module dmafe_decode
    import dmafe_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    always_comb begin
        dec          = '0;
        dec.wr_ctrl  = wr_en && (addr == ADDR_W'(OFF_CTRL));
        dec.wr_addr  = wr_en && (addr == ADDR_W'(OFF_ADDR));
        dec.wr_bank  = wr_en && (addr == ADDR_W'(OFF_BANK));
        dec.wr_start = wr_en && (addr == ADDR_W'(OFF_START));
        dec.wr_stop  = wr_en && (addr == ADDR_W'(OFF_STOP));
        dec.wr_mask  = wr_en && (addr == ADDR_W'(OFF_MASK));
        dec.rd_ctrl  = rd_en && (addr == ADDR_W'(OFF_CTRL));
    end
endmodule

// File: rtl/dmafe_status.sv
module dmafe_status
    import dmafe_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  dec_t  dec,
    input  logic  wr_ie,
    input  logic  wr_dir,
    input  logic  eng_done_i,
    input  logic  chip_irq_i,
    output ctrl_t st,
    output logic  eng_start_o,
    output logic  eng_stop_o,
    output logic  host_irq_o
);
    logic done_ok;
    logic pend_set;

    // Completion only counts while a transfer runs and no strobe overrides it
    assign done_ok  = eng_done_i && st.busy && !dec.wr_start && !dec.wr_stop;
    assign pend_set = chip_irq_i || done_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= '0;
            eng_start_o <= 1'b0;
            eng_stop_o  <= 1'b0;
        end else begin
            eng_start_o <= dec.wr_start;
            eng_stop_o  <= dec.wr_stop;
            if (dec.wr_ctrl) begin
                st.ie  <= wr_ie;
                st.dir <= wr_dir;
            end
            if (dec.wr_start)
                st.busy <= 1'b1;
            else if (dec.wr_stop || done_ok)
                st.busy <= 1'b0;
            if (pend_set)
                st.pend <= 1'b1;
            else if (dec.rd_ctrl)
                st.pend <= 1'b0;
        end
    end

    assign host_irq_o = st.pend && st.ie;
endmodule

// File: rtl/dmafe_addr.sv
module dmafe_addr
    import dmafe_pkg::*;
#(
    parameter int          DATA_W     = 32,
    parameter int          BANK_W     = 3,
    parameter int          BANK_SRC   = 24,
    parameter int          BANK_POS   = 6,
    parameter logic [31:0] MASK_RESET = 32'hFF00_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  dec_t              dec,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] addr_q,
    output logic [BANK_W-1:0] bank_q,
    output logic [DATA_W-1:0] mask_q,
    output logic [DATA_W-1:0] eng_addr_o,
    output logic              range_err_o
);
    logic [BANK_W-1:0] bank_allow;

    assign bank_allow = ~mask_q[BANK_SRC +: BANK_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            bank_q <= '0;
            mask_q <= DATA_W'(MASK_RESET);
        end else begin
            if (dec.wr_addr) addr_q <= wdata;
            if (dec.wr_mask) mask_q <= wdata;
            if (dec.wr_bank) bank_q <= wdata[BANK_POS +: BANK_W] & bank_allow;
        end
    end

    // Merge the bank bits over the matching address field
    always_comb begin
        eng_addr_o = addr_q;
        for (int i = 0; i < BANK_W; i++)
            eng_addr_o[BANK_SRC + i] = bank_q[i];
    end

    assign range_err_o = |(addr_q & mask_q);
endmodule

// File: rtl/dmafe_top.sv
module dmafe_top
    import dmafe_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter int          DATA_W     = 32,
    parameter int          BANK_W     = 3,
    parameter int          BANK_SRC   = 24,
    parameter int          BANK_POS   = 6,
    parameter logic [31:0] MASK_RESET = 32'hFF00_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              clk_sel_i,
    input  logic              eng_done_i,
    input  logic              chip_irq_i,
    output logic              eng_start_o,
    output logic              eng_stop_o,
    output logic              eng_dir_o,
    output logic [DATA_W-1:0] eng_addr_o,
    output logic              range_err_o,
    output logic              host_irq_o
);
    dec_t              dec;
    ctrl_t             st;
    logic [DATA_W-1:0] addr_q;
    logic [DATA_W-1:0] mask_q;
    logic [BANK_W-1:0] bank_q;
    logic              busy_w;
    logic              pend_w;
    logic              ie_w;

    dmafe_decode #(.ADDR_W(ADDR_W)) u_dec (
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .dec   (dec)
    );

    dmafe_status u_st (
        .clk         (clk),
        .rst         (rst),
        .dec         (dec),
        .wr_ie       (wdata[B_IE]),
        .wr_dir      (wdata[B_DIR]),
        .eng_done_i  (eng_done_i),
        .chip_irq_i  (chip_irq_i),
        .st          (st),
        .eng_start_o (eng_start_o),
        .eng_stop_o  (eng_stop_o),
        .host_irq_o  (host_irq_o)
    );

    dmafe_addr #(
        .DATA_W     (DATA_W),
        .BANK_W     (BANK_W),
        .BANK_SRC   (BANK_SRC),
        .BANK_POS   (BANK_POS),
        .MASK_RESET (MASK_RESET)
    ) u_addr (
        .clk         (clk),
        .rst         (rst),
        .dec         (dec),
        .wdata       (wdata),
        .addr_q      (addr_q),
        .bank_q      (bank_q),
        .mask_q      (mask_q),
        .eng_addr_o  (eng_addr_o),
        .range_err_o (range_err_o)
    );

    assign eng_dir_o = st.dir;
    assign busy_w    = st.busy;
    assign pend_w    = st.pend;
    assign ie_w      = st.ie;

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(OFF_CTRL):   rdata = DATA_W'(ctrl_word(st));
            ADDR_W'(OFF_ADDR):   rdata = addr_q;
            ADDR_W'(OFF_BANK):   rdata[BANK_POS +: BANK_W] = bank_q;
            ADDR_W'(OFF_MASK):   rdata = mask_q;
            ADDR_W'(OFF_CLKSEL): rdata[0] = clk_sel_i;
            default:             rdata = '0;
        endcase
    end
endmodule

// File: rtl/dmafe_checker.sv
module dmafe_checker
    import dmafe_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              eng_done_i,
    input logic              chip_irq_i,
    input logic              eng_start_o,
    input logic              eng_stop_o,
    input logic              host_irq_o,
    input logic              busy,
    input logic              pend
);
    a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(OFF_START)) |=> (busy && eng_start_o));

    a_r3_stop_clears_busy: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(OFF_STOP)) |=> (!busy && eng_stop_o));

    a_r4_done_flags: assert property (@(posedge clk) disable iff (rst)
        (eng_done_i && busy && !wr_en) |=> (pend && !busy));

    a_r4_idle_done_quiet: assert property (@(posedge clk) disable iff (rst)
        (eng_done_i && !busy && !pend && !chip_irq_i && !wr_en) |=> !pend);

    a_r5_irq_gated_off: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(OFF_CTRL) && !wdata[B_IE]) |=> !host_irq_o);

    a_r6_read_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == ADDR_W'(OFF_CTRL) && !chip_irq_i && !eng_done_i) |=> !pend);

    a_r11_chip_sets: assert property (@(posedge clk) disable iff (rst)
        chip_irq_i |=> pend);
endmodule

bind dmafe_top dmafe_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .addr        (addr),
    .wdata       (wdata),
    .eng_done_i  (eng_done_i),
    .chip_irq_i  (chip_irq_i),
    .eng_start_o (eng_start_o),
    .eng_stop_o  (eng_stop_o),
    .host_irq_o  (host_irq_o),
    .busy        (busy_w),
    .pend        (pend_w)
);

// File: tb/tb_dmafe_top.sv
module tb_dmafe_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        clk_sel_i = 1'b0;
    logic        eng_done_i = 1'b0;
    logic        chip_irq_i = 1'b0;
    logic        eng_start_o, eng_stop_o, eng_dir_o, range_err_o, host_irq_o;
    logic [31:0] eng_addr_o;

    int errors = 0;
    int checks = 0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } exp_t;
    exp_t sb[$];
    exp_t mon_e;

    always #4 clk = ~clk;

    dmafe_top dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .clk_sel_i(clk_sel_i),
        .eng_done_i(eng_done_i), .chip_irq_i(chip_irq_i),
        .eng_start_o(eng_start_o), .eng_stop_o(eng_stop_o),
        .eng_dir_o(eng_dir_o), .eng_addr_o(eng_addr_o),
        .range_err_o(range_err_o), .host_irq_o(host_irq_o)
    );

    // Monitor: compare every read against the scoreboard
    always @(negedge clk) begin
        if (rd_en) begin
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL scoreboard empty: rdata=%h expected none", rdata);
            end else begin
                mon_e = sb.pop_front();
                if (rdata !== mon_e.exp) begin
                    errors++;
                    $display("FAIL %s: rdata=%h expected %h", mon_e.tag, rdata, mon_e.exp);
                end
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [15:0] off, logic [31:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; addr = off; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [15:0] off, logic [31:0] exp, string tag);
        exp_t e;
        @(posedge clk); #1;
        rd_en = 1'b1; addr = off;
        e.exp = exp; e.tag = tag;
        sb.push_back(e);
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic pulse_done();
        @(posedge clk); #1; eng_done_i = 1'b1;
        @(posedge clk); #1; eng_done_i = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        chk("R1 start", {31'b0, eng_start_o}, 0);
        chk("R1 irq", {31'b0, host_irq_o}, 0);
        rd(16'h0000, 32'h0, "R1 ctrl");
        rd(16'h0014, 32'hFF00_0000, "R1 mask");
        rd(16'h0008, 32'h0, "R1 bank");

        // R7 control write
        wr(16'h0000, 32'h3);
        chk("R7 dir", {31'b0, eng_dir_o}, 1);
        rd(16'h0000, 32'h3, "R7 ctrl");
        wr(16'h0000, 32'hFFFF_FFFF);
        rd(16'h0000, 32'h3, "R7 status bits ignore data");

        // R8 address
        wr(16'h0004, 32'h1234_5678);
        rd(16'h0004, 32'h1234_5678, "R8 addr readback");
        chk("R10 range err default", {31'b0, range_err_o}, 1);
        // R9 bank with default mask: all bank bits blocked
        wr(16'h0008, 32'h1C0);
        rd(16'h0008, 32'h0, "R9 bank blocked");

        // R2 start
        wr(16'h000C, 32'hDEAD_BEEF);
        chk("R2 start pulse", {31'b0, eng_start_o}, 1);
        @(posedge clk); #1;
        chk("R2 start pulse one cycle", {31'b0, eng_start_o}, 0);
        rd(16'h0000, 32'hB, "R2 busy");

        // R4 completion, R5 irq, R6 read clear
        pulse_done();
        chk("R5 irq on", {31'b0, host_irq_o}, 1);
        rd(16'h0000, 32'h7, "R4 done sets pend");
        chk("R6 irq cleared", {31'b0, host_irq_o}, 0);
        rd(16'h0000, 32'h3, "R6 pend cleared");

        // R4 idle completion ignored
        wr(16'h0000, 32'h0);
        pulse_done();
        rd(16'h0000, 32'h0, "R4 idle done ignored");

        // R3 stop
        wr(16'h000C, 32'h0);
        wr(16'h0010, 32'h5);
        chk("R3 stop pulse", {31'b0, eng_stop_o}, 1);
        rd(16'h0000, 32'h0, "R3 busy cleared");

        // R11 chip irq, R5 gating
        @(posedge clk); #1; chip_irq_i = 1'b1;
        @(posedge clk); #1; chip_irq_i = 1'b0;
        chk("R5 gated by ie", {31'b0, host_irq_o}, 0);
        wr(16'h0000, 32'h1);
        chk("R5 irq after enable", {31'b0, host_irq_o}, 1);
        // R6 set wins over read clear
        @(posedge clk); #1; chip_irq_i = 1'b1;
        rd(16'h0000, 32'h5, "R11 pend from chip");
        chip_irq_i = 1'b0;
        rd(16'h0000, 32'h5, "R6 set wins over clear");
        rd(16'h0000, 32'h1, "R6 cleared on later read");
        chk("R6 irq low", {31'b0, host_irq_o}, 0);

        // R9/R10 under 128 MB mask
        wr(16'h0014, 32'hF800_0000);
        wr(16'h0004, 32'h0734_5678);
        wr(16'h0008, 32'h1C0);
        rd(16'h0008, 32'h1C0, "R9 bank all allowed");
        chk("R8 merged addr", eng_addr_o, 32'h0734_5678);
        chk("R10 in range", {31'b0, range_err_o}, 0);

        // R9/R10 under 32 MB mask
        wr(16'h0014, 32'hFE00_0000);
        chk("R10 out of range", {31'b0, range_err_o}, 1);
        wr(16'h0008, 32'h1C0);
        rd(16'h0008, 32'h040, "R9 bank partial");
        chk("R8 merged addr bank1", eng_addr_o, 32'h0134_5678);

        // R12 clock strap and unmapped
        clk_sel_i = 1'b1;
        rd(16'h8000, 32'h1, "R12 clk sel high");
        clk_sel_i = 1'b0;
        rd(16'h8000, 32'h0, "R12 clk sel low");
        rd(16'h0020, 32'h0, "R12 unmapped");
        rd(16'h000C, 32'h0, "R12 strobe reads zero");

        repeat (3) @(posedge clk);
        if (sb.size() != 0) begin
            checks++; errors++;
            $display("FAIL scoreboard: actual=%0d left expected=0", sb.size());
        end
        finish_run();
    end
endmodule